// File: doc/BRIEF.md
# Operand Address Breakpoint Comparator

This block watches the data-side bus of a processor core and raises a break when an operand access meets a programmed condition. Each access presents a byte address, an access size and a read/write flag. Software programs two break addresses, a don't-care mask and a control word through a simple write port. The comparator offers a point match on each break address, a range match strictly between the two, bit masking of all comparisons, and qualifiers on access size and direction.

A qualifying access produces a one-cycle break pulse on the next clock. At the same edge a two-bit status code is latched that tells a point-0 hit, a point-1 hit and a range hit apart. The access interface is a valid/ready stream that never applies back-pressure: `acc_ready` is held high and every cycle with `acc_valid` high is one accepted access. Register writes and accesses may share a cycle. An access is always judged with the settings held before that cycle's write.

Top module: `opnd_brk_cmp`

## Requirements
- R1: After reset, all enables, both direction-qualifier bits and the status are zero, and `brk_pulse` is low. While the point-0, point-1 and range enables are all clear, no access produces a break.
- R2: Control word bit 0 enables a point match on break address 0 (select 0). A hit latches status 2'b01.
- R3: Control word bit 1 enables a point match on break address 1 (select 1). A hit latches status 2'b10.
- R4: Control word bit 2 enables a range match. It hits only when the address is strictly greater than break address 0 and strictly less than break address 1, and it latches status 2'b11. An address equal to either bound is never a range hit.
- R5: When control word bit 3 is set, every address bit that is 1 in the mask register (select 2) is ignored in the point and range comparisons.
- R6: An access with `acc_size`=00 (byte) hits a point only when the full byte address matches.
- R7: An access with `acc_size`=01 (halfword) hits a point that lies in the same aligned 2-byte pair (address bit 0 is ignored).
- R8: An access with `acc_size`=10 (word) hits a point that lies in the same aligned 4-byte word. `acc_size`=11 behaves as a word.
- R9: Control word bits [5:4] qualify the size: 00 = any, 01 = byte only, 10 = halfword only, 11 = word only.
- R10: Control word bits [7:6] qualify the direction, with `acc_write`=1 meaning a write: 00 = never break, 01 = reads only, 10 = writes only, 11 = both.
- R11: `brk_pulse` is high for exactly the cycle after each qualifying access, so back-to-back hits give back-to-back pulses. The status holds its value until any write to select 4 clears it.
- R12: A register write takes effect for accesses from the next cycle on. If a new hit and a clear write fall in the same cycle, the new code is latched.
- R13: When several matches hit at once, point 0 wins over point 1, and both win over the range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Operand access present this cycle |
| acc_ready | output | 1 | Always high; the block never stalls the bus |
| acc_addr | input | AW | Byte address of the access |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_write | input | 1 | 1 = write, 0 = read |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 break addr 0, 1 break addr 1, 2 mask, 3 control, 4 status clear |
| reg_wdata | input | AW | Write data; control uses bits [7:0] |
| brk_pulse | output | 1 | One-cycle break indication |
| brk_status | output | 2 | Latched hit code (01, 10, 11) |

## Verification
The hardest cases to reach are the ones where more than one match fires on a single access: a word access covering break address 0 while also lying inside the range, or both break addresses set equal. The stimulus reaches them by reprogramming the break addresses so that these overlaps happen on purpose. The same-cycle cases are also hard to reach, and the bench covers them with a task that drives an access and a register write on the same edge. A behavioural model sweeps the bytes each access covers and compares pulse and status on every clock.

// File: rtl/obk_pkg.sv
package obk_pkg;

  // Register selects on the write port
  localparam logic [2:0] SEL_BP0  = 3'd0;
  localparam logic [2:0] SEL_BP1  = 3'd1;
  localparam logic [2:0] SEL_MASK = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_CLR  = 3'd4;

  // Access size codes
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [1:0] {
    HIT_NONE = 2'b00,
    HIT_PT0  = 2'b01,
    HIT_PT1  = 2'b10,
    HIT_RNG  = 2'b11
  } hit_code_e;

  // Control word, packed so that bit 0 is pt0_en
  typedef struct packed {
    logic [1:0] rw_q;
    logic [1:0] sz_q;
    logic       msk_en;
    logic       rng_en;
    logic       pt1_en;
    logic       pt0_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/obk_regs.sv
module obk_regs
  import obk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] bp_q [2],
  output logic [AW-1:0] mask_q,
  output ctrl_t         cfg_q,
  output logic          clr_req
);

  localparam int NBP = 2;

  generate
    for (genvar i = 0; i < NBP; i++) begin : g_bp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bp_q[i] <= '0;
        end else if (reg_we && reg_sel == 3'(SEL_BP0 + i)) begin
          bp_q[i] <= reg_wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (reg_we && reg_sel == SEL_MASK) begin
      mask_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (reg_we && reg_sel == SEL_CTRL) begin
      cfg_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
  end

  assign clr_req = reg_we && (reg_sel == SEL_CLR);

endmodule

// File: rtl/obk_match.sv
module obk_match
  import obk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic          acc_write,
  input  logic [AW-1:0] bp_q [2],
  input  logic [AW-1:0] mask_q,
  input  ctrl_t         cfg_q,
  output logic          hit,
  output hit_code_e     code
);

  localparam int NBP = 2;

  logic [1:0]    sz_eff;
  logic [AW-1:0] mk;
  logic [AW-1:0] lane_ign;
  logic [AW-1:0] pt_ign;
  logic [NBP-1:0] pt_en;
  logic [NBP-1:0] pt_hit;
  logic          rng_hit;
  logic          sz_ok;
  logic          rw_ok;

  assign sz_eff = (acc_size == 2'b11) ? SZ_WORD : acc_size;
  assign mk     = cfg_q.msk_en ? mask_q : '0;

  always_comb begin
    lane_ign = '0;
    case (sz_eff)
      SZ_HALF: lane_ign[0]   = 1'b1;
      SZ_WORD: lane_ign[1:0] = 2'b11;
      default: lane_ign      = '0;
    endcase
  end

  assign pt_ign = mk | lane_ign;
  assign pt_en  = {cfg_q.pt1_en, cfg_q.pt0_en};

  generate
    for (genvar i = 0; i < NBP; i++) begin : g_pt
      assign pt_hit[i] = pt_en[i] && (((acc_addr ^ bp_q[i]) & ~pt_ign) == '0);
    end
  endgenerate

  logic [AW-1:0] a_m, lo_m, hi_m;
  assign a_m  = acc_addr & ~mk;
  assign lo_m = bp_q[0]  & ~mk;
  assign hi_m = bp_q[1]  & ~mk;
  assign rng_hit = cfg_q.rng_en && (a_m > lo_m) && (a_m < hi_m);

  assign sz_ok = (cfg_q.sz_q == 2'b00) || (cfg_q.sz_q == 2'(sz_eff + 2'd1));
  assign rw_ok = acc_write ? cfg_q.rw_q[1] : cfg_q.rw_q[0];

  assign hit = acc_valid && sz_ok && rw_ok && ((|pt_hit) || rng_hit);

  always_comb begin
    if (pt_hit[0])      code = HIT_PT0;
    else if (pt_hit[1]) code = HIT_PT1;
    else if (rng_hit)   code = HIT_RNG;
    else                code = HIT_NONE;
  end

endmodule

// File: rtl/obk_status.sv
module obk_status
  import obk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  hit_code_e code,
  input  logic      clr_req,
  output logic      brk_pulse,
  output logic [1:0] brk_status
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_pulse  <= 1'b0;
      brk_status <= HIT_NONE;
    end else begin
      brk_pulse <= hit;
      if (hit) begin
        brk_status <= code;
      end else if (clr_req) begin
        brk_status <= HIT_NONE;
      end
    end
  end

endmodule

// File: rtl/opnd_brk_cmp.sv
module opnd_brk_cmp
  import obk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic          acc_write,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic          brk_pulse,
  output logic [1:0]    brk_status
);

  logic [AW-1:0] bp_q [2];
  logic [AW-1:0] mask_q;
  ctrl_t         cfg_q;
  logic          clr_req;
  logic          hit;
  hit_code_e     code;

  assign acc_ready = 1'b1;

  obk_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .bp_q     (bp_q),
    .mask_q   (mask_q),
    .cfg_q    (cfg_q),
    .clr_req  (clr_req)
  );

  obk_match #(.AW(AW)) u_match (
    .acc_valid(acc_valid),
    .acc_addr (acc_addr),
    .acc_size (acc_size),
    .acc_write(acc_write),
    .bp_q     (bp_q),
    .mask_q   (mask_q),
    .cfg_q    (cfg_q),
    .hit      (hit),
    .code     (code)
  );

  obk_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .code      (code),
    .clr_req   (clr_req),
    .brk_pulse (brk_pulse),
    .brk_status(brk_status)
  );

endmodule

// File: rtl/opnd_brk_chk.sv
module opnd_brk_chk
  import obk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       reg_we,
  input logic [2:0] reg_sel,
  input ctrl_t      cfg_q,
  input logic       brk_pulse,
  input logic [1:0] brk_status
);

  AST_PULSE_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(acc_valid)); // R11

  AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> ($past(cfg_q.pt0_en) || $past(cfg_q.pt1_en) || $past(cfg_q.rng_en))); // R1

  AST_PULSE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> ($past(cfg_q.rw_q) != 2'b00)); // R10

  AST_STATUS_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> (brk_status != 2'b00)); // R11

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_pulse && !$past(reg_we && reg_sel == SEL_CLR)) |-> $stable(brk_status)); // R11

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_pulse && $past(reg_we && reg_sel == SEL_CLR)) |-> (brk_status == 2'b00)); // R11

  AST_RANGE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pulse && brk_status == 2'b11) |-> $past(cfg_q.rng_en)); // R4

  AST_PT1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pulse && brk_status == 2'b10) |-> $past(cfg_q.pt1_en)); // R3

endmodule

bind opnd_brk_cmp opnd_brk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .cfg_q     (cfg_q),
  .brk_pulse (brk_pulse),
  .brk_status(brk_status)
);

// File: tb/test_opnd_brk_cmp.sv
module test_opnd_brk_cmp;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_ready;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_size = 2'b00;
  logic          acc_write = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic          brk_pulse;
  logic [1:0]    brk_status;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  opnd_brk_cmp #(.AW(AW)) i_opnd_brk_cmp (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_write(acc_write),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .brk_pulse(brk_pulse), .brk_status(brk_status)
  );

  // ---------------- behavioural reference ----------------
  logic [AW-1:0] m_bp0, m_bp1, m_mask;
  logic [7:0]    m_ctl;
  logic          exp_pulse;
  logic [1:0]    exp_status;

  function automatic logic [1:0] ref_code(input logic [AW-1:0] a, input logic [1:0] s,
                                          input logic w);
    int nbytes;
    int eff;
    logic [AW-1:0] base, m;
    bit p0, p1, rg, dir_ok, sz_ok;
    eff = (s == 2'b11) ? 2 : int'(s);
    nbytes = 1 << eff;
    base = a - (a % nbytes);
    m = m_ctl[3] ? m_mask : '0;
    case (m_ctl[7:6])
      2'b01:   dir_ok = !w;
      2'b10:   dir_ok = w;
      2'b11:   dir_ok = 1;
      default: dir_ok = 0;
    endcase
    sz_ok = (m_ctl[5:4] == 2'b00) || (int'(m_ctl[5:4]) == eff + 1);
    p0 = 0; p1 = 0;
    for (int k = 0; k < nbytes; k++) begin
      if (((base + AW'(k)) & ~m) == (m_bp0 & ~m)) p0 = 1;
      if (((base + AW'(k)) & ~m) == (m_bp1 & ~m)) p1 = 1;
    end
    p0 = p0 && m_ctl[0];
    p1 = p1 && m_ctl[1];
    rg = m_ctl[2] && ((a & ~m) > (m_bp0 & ~m)) && ((a & ~m) < (m_bp1 & ~m));
    if (!dir_ok || !sz_ok) return 2'b00;
    if (p0) return 2'b01;
    if (p1) return 2'b10;
    if (rg) return 2'b11;
    return 2'b00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bp0 = '0; m_bp1 = '0; m_mask = '0; m_ctl = '0;
      exp_pulse <= 1'b0;
      exp_status <= 2'b00;
    end else begin
      logic [1:0] c;
      c = acc_valid ? ref_code(acc_addr, acc_size, acc_write) : 2'b00;
      exp_pulse <= (c != 2'b00);
      if (c != 2'b00) exp_status <= c;
      else if (reg_we && reg_sel == 3'd4) exp_status <= 2'b00;
      if (reg_we) begin
        case (reg_sel)
          3'd0: m_bp0 = reg_wdata;
          3'd1: m_bp1 = reg_wdata;
          3'd2: m_mask = reg_wdata;
          3'd3: m_ctl = reg_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    vectors++;
    if (brk_pulse !== exp_pulse || brk_status !== exp_status || acc_ready !== 1'b1) begin
      fails++;
      $display("FAIL %s t=%0t: pulse=%b status=%b ready=%b expected pulse=%b status=%b ready=1",
               cur_req, $time, brk_pulse, brk_status, acc_ready, exp_pulse, exp_status);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic acc(input logic [AW-1:0] a, input logic [1:0] s, input logic w);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = s; acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic acc_and_wr(input logic [AW-1:0] a, input logic [1:0] s, input logic w,
                            input logic [2:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = s; acc_write = w;
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(2);
    acc(32'h0000_0000, 2'b10, 1'b0);
    acc(32'h1234_5200, 2'b00, 1'b1);
    idle(2);

    wr(3'd0, 32'h1234_5200);
    wr(3'd1, 32'h1234_5300);
    wr(3'd2, 32'h0000_0000);
    wr(3'd3, 32'h0000_0000);
    cur_req = "R1";
    acc(32'h1234_5200, 2'b00, 1'b0);           // no enables
    wr(3'd3, 32'h0000_00C7);                   // pt0, pt1, range, any size, both dirs

    cur_req = "R2";
    acc(32'h1234_5200, 2'b00, 1'b0);
    cur_req = "R3";
    acc(32'h1234_5300, 2'b00, 1'b1);

    cur_req = "R4";
    acc(32'h1234_5280, 2'b00, 1'b0);
    acc(32'h1234_5301, 2'b00, 1'b0);
    acc(32'h1234_51FF, 2'b00, 1'b0);
    wr(3'd3, 32'h0000_00C4);                   // range only
    acc(32'h1234_5200, 2'b00, 1'b0);           // lower bound: not inside
    acc(32'h1234_5300, 2'b00, 1'b0);           // upper bound: not inside
    acc(32'h1234_5201, 2'b00, 1'b0);

    cur_req = "R5";
    wr(3'd2, 32'hF000_0000);
    wr(3'd3, 32'h0000_00CB);                   // mask, pt1, pt0
    acc(32'h0234_5200, 2'b00, 1'b0);
    acc(32'h2234_5300, 2'b00, 1'b1);
    acc(32'h1234_5201, 2'b00, 1'b0);
    wr(3'd3, 32'h0000_00CC);                   // mask, range
    acc(32'h3234_5250, 2'b00, 1'b0);
    acc(32'h3234_5350, 2'b00, 1'b0);

    cur_req = "R6";
    wr(3'd3, 32'h0000_00C3);
    wr(3'd0, 32'h1234_5202);
    acc(32'h1234_5202, 2'b00, 1'b0);
    acc(32'h1234_5203, 2'b00, 1'b0);
    acc(32'h1234_5201, 2'b00, 1'b0);

    cur_req = "R7";
    acc(32'h1234_5203, 2'b01, 1'b0);
    acc(32'h1234_5201, 2'b01, 1'b0);
    wr(3'd0, 32'h1234_5201);
    acc(32'h1234_5200, 2'b01, 1'b0);
    acc(32'h1234_5202, 2'b01, 1'b0);
    wr(3'd0, 32'h1234_5202);

    cur_req = "R8";
    acc(32'h1234_5200, 2'b10, 1'b0);
    acc(32'h1234_5204, 2'b10, 1'b0);
    acc(32'h1234_5201, 2'b11, 1'b1);
    acc(32'h1234_53FC, 2'b10, 1'b0);
    acc(32'h1234_5302, 2'b10, 1'b0);

    cur_req = "R9";
    wr(3'd3, 32'h0000_00D3);                   // bytes only
    acc(32'h1234_5200, 2'b10, 1'b0);
    acc(32'h1234_5202, 2'b00, 1'b0);
    wr(3'd3, 32'h0000_00E3);                   // halfwords only
    acc(32'h1234_5202, 2'b00, 1'b0);
    acc(32'h1234_5203, 2'b01, 1'b0);
    wr(3'd3, 32'h0000_00F3);                   // words only
    acc(32'h1234_5202, 2'b00, 1'b0);
    acc(32'h1234_5203, 2'b10, 1'b0);

    cur_req = "R10";
    wr(3'd3, 32'h0000_0043);                   // reads only
    acc(32'h1234_5202, 2'b00, 1'b1);
    acc(32'h1234_5202, 2'b00, 1'b0);
    wr(3'd3, 32'h0000_0083);                   // writes only
    acc(32'h1234_5202, 2'b00, 1'b0);
    acc(32'h1234_5202, 2'b00, 1'b1);
    wr(3'd3, 32'h0000_0003);                   // never
    acc(32'h1234_5202, 2'b00, 1'b0);
    acc(32'h1234_5202, 2'b00, 1'b1);

    cur_req = "R11";
    wr(3'd3, 32'h0000_00C7);
    acc(32'h1234_5300, 2'b00, 1'b0);
    idle(5);
    wr(3'd4, 32'h0000_0000);
    idle(2);
    @(negedge clk);                             // back-to-back hits
    acc_valid = 1'b1; acc_addr = 32'h1234_5202; acc_size = 2'b00; acc_write = 1'b0;
    @(negedge clk);
    acc_addr = 32'h1234_5280;
    @(negedge clk);
    acc_addr = 32'h1234_5300;
    @(negedge clk);
    acc_valid = 1'b0;
    idle(3);
    wr(3'd7, 32'h0000_0000);                    // unused select: status stays

    cur_req = "R12";
    acc_and_wr(32'h1234_5202, 2'b00, 1'b0, 3'd3, 32'h0000_0000);
    acc(32'h1234_5202, 2'b00, 1'b0);
    wr(3'd3, 32'h0000_00C7);
    wr(3'd4, 32'h0000_0000);
    acc_and_wr(32'h1234_5300, 2'b00, 1'b0, 3'd4, 32'h0000_0000);
    idle(2);
    acc_and_wr(32'h1234_5202, 2'b00, 1'b0, 3'd0, 32'h1234_5250);
    acc(32'h1234_5202, 2'b00, 1'b0);
    acc(32'h1234_5250, 2'b00, 1'b0);

    cur_req = "R13";
    wr(3'd0, 32'h1234_5202);
    wr(3'd1, 32'h1234_5202);
    acc(32'h1234_5202, 2'b00, 1'b0);
    wr(3'd1, 32'h1234_5300);
    acc(32'h1234_5203, 2'b10, 1'b0);
    wr(3'd0, 32'h1234_5200);
    acc(32'h1234_5301, 2'b10, 1'b0);
    acc(32'h1234_52FF, 2'b10, 1'b0);
    idle(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog: actual=still running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule